// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block executes the two flag-conditioned relative branches of a byte-addressed core whose instruction cycle is four phases long. It takes each fetched 16-bit instruction word and the zero and overflow status flags. The upper byte of the word selects the condition. The lower byte is a signed word offset. The block owns the program counter, which always holds the byte address of the instruction being executed.

A branch is taken when its tested flag is clear. The new counter value is the sequential address (current address plus 2) plus twice the sign-extended offset, and the sum wraps at the counter width. A taken branch raises `taken` in its fourth phase. It then raises `flush` for the whole of the following instruction cycle. During that cycle whatever word is presented is discarded and executed as a no-operation, so a taken branch costs two cycles and an untaken one costs one. The phase sequencer moves one phase per clock on which `phase_stb` is high. No status flag is ever written.

Top module: `cbr_unit`

## Requirements
- R1: A word whose upper byte is 0xE1 is the branch-if-not-zero form. It is taken exactly when `flag_zero` was 0 at the end of phase 1. `flag_ovf` has no bearing on it.
- R2: A word whose upper byte is 0xE5 is the branch-if-not-overflow form. It is taken exactly when `flag_ovf` was 0 at the end of phase 1. `flag_zero` has no bearing on it.
- R3: A taken branch loads `pc` with (address + 2 + 2*n) modulo 2^PC_W. Here n is bits 7:0 of the word, read as two's complement (-128..127) at the end of phase 2.
- R4: An untaken branch, or any word that is not taken, advances `pc` by 2 at the end of phase 4 and leaves `flush` low.
- R5: `taken` is high only during phase 4 of a taken branch. At the end of that phase `flush` rises.
- R6: While `flush` is high, the presented word is ignored, `taken` stays low and `pc` is left unchanged at the end of phase 4. `flush` then falls.
- R7: The flag tested is the value at the end of phase 1. Flag changes during phases 2 to 4 do not alter the decision.
- R8: A word whose upper byte is neither 0xE1 nor 0xE5 never raises `taken` or `flush`, whatever the flags and the lower byte hold.
- R9: Phases advance only on clocks with `phase_stb` high. On any other clock `pc`, `taken` and `flush` hold.
- R10: A synchronous `rst` sets `pc` to 0, clears `taken` and `flush`, and returns the sequencer to phase 1.
- R11: `pc` changes only at the end of phase 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_stb | input | 1 | Advance the phase sequencer by one phase on this clock |
| instr | input | 16 | Instruction word, held steady through the instruction cycle |
| flag_zero | input | 1 | Zero status flag |
| flag_ovf | input | 1 | Overflow status flag |
| pc | output | PC_W | Byte address of the instruction being executed |
| taken | output | 1 | Branch taken, high in phase 4 of the branch |
| flush | output | 1 | The current instruction cycle is a forced no-operation |

## Verification
The bench builds the unit with a 10-bit counter instead of the 21-bit default. With random offsets a random walk of taken branches then wraps through both ends of the address space many times, and a directed backward jump of -128 from near zero wraps on purpose. Random idle clocks between strobes exercise phase holding. Flags are inverted after phase 1 to show the decision is fixed early. A reset is also asserted mid-branch.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    // Condition slot 0 tests zero, slot 1 tests overflow
    localparam int NUM_COND = 2;
    localparam logic [NUM_COND-1:0][7:0] COND_OPC = {8'hE5, 8'hE1};

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

endpackage

// File: rtl/cbr_phase.sv
module cbr_phase
    import cbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stb,
    output phase_e phase
);

    phase_e phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (stb) begin
            phase_d = phase_e'(2'(phase_q) + 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_Q1;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    logic [1:0] ph_bits;
    assign ph_bits = 2'(phase_q);

    // R9
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        stb |=> (ph_bits == 2'($past(ph_bits) + 2'd1)));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(ph_bits));

endmodule

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       flag_zero,
    input  logic       flag_ovf,
    output logic       hit,
    output logic       tested_flag
);

    logic [NUM_COND-1:0] match;
    logic [NUM_COND-1:0] flags;

    assign flags = {flag_ovf, flag_zero};

    for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
        assign match[i] = (opc == COND_OPC[i]);
    end

    assign hit         = |match;
    assign tested_flag = |(match & flags);

    // R8
    always_comb begin
        if (!hit) one_cond_chk: assert (!tested_flag);
    end

endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
    parameter int PC_W = 21
) (
    input  logic [PC_W-1:0] base,
    input  logic [7:0]      off,
    output logic [PC_W-1:0] next_seq,
    output logic [PC_W-1:0] target
);

    localparam int EXT_W = PC_W - 9;
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

    logic [PC_W-1:0] disp;

    assign disp     = {{EXT_W{off[7]}}, off, 1'b0};
    assign next_seq = base + INSN_BYTES;
    assign target   = next_seq + disp;

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phase_stb,
    input  logic [15:0]     instr,
    input  logic            flag_zero,
    input  logic            flag_ovf,
    output logic [PC_W-1:0] pc,
    output logic            taken,
    output logic            flush
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            is_br;
        logic            flag;
        logic [7:0]      off;
        logic [PC_W-1:0] tgt;
        logic            taken;
        logic            flush;
    } unit_st_t;

    unit_st_t        r_d, r_q;
    phase_e          phase;
    logic            dec_hit, dec_flag;
    logic [PC_W-1:0] seq_pc, br_pc;

    cbr_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .stb   (phase_stb),
        .phase (phase)
    );

    cbr_decode u_dec (
        .opc         (instr[15:8]),
        .flag_zero   (flag_zero),
        .flag_ovf    (flag_ovf),
        .hit         (dec_hit),
        .tested_flag (dec_flag)
    );

    cbr_target #(.PC_W(PC_W)) u_tgt (
        .base     (r_q.pc),
        .off      (r_q.off),
        .next_seq (seq_pc),
        .target   (br_pc)
    );

    always_comb begin
        r_d = r_q;
        if (phase_stb) begin
            case (phase)
                PH_Q1: begin
                    r_d.is_br = dec_hit & ~r_q.flush;
                    r_d.flag  = dec_flag;
                end
                PH_Q2: begin
                    r_d.off = instr[7:0];
                end
                PH_Q3: begin
                    r_d.tgt   = br_pc;
                    r_d.taken = r_q.is_br & ~r_q.flag;
                end
                PH_Q4: begin
                    r_d.taken = 1'b0;
                    r_d.is_br = 1'b0;
                    if (r_q.flush) begin
                        r_d.flush = 1'b0;
                    end else if (r_q.taken) begin
                        r_d.pc    = r_q.tgt;
                        r_d.flush = 1'b1;
                    end else begin
                        r_d.pc = seq_pc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign pc    = r_q.pc;
    assign taken = r_q.taken;
    assign flush = r_q.flush;

    // R5
    taken_q4_chk: assert property (@(posedge clk) disable iff (rst)
        taken |-> (phase == PH_Q4));

    // R5
    flush_set_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_stb && phase == PH_Q4 && taken) |=> flush);

    // R6
    flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_stb && phase == PH_Q4 && flush) |=> ($stable(pc) && !flush));

    // R6
    no_take_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !taken);

    // R11
    pc_q4_only_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_stb && phase != PH_Q4) |=> $stable(pc));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_stb |=> ($stable(pc) && $stable(flush) && $stable(taken)));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_stb && phase == PH_Q4 && !flush && !taken)
            |=> (pc == $past(pc) + PC_W'(2)));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && !flush && !taken && phase == PH_Q1));

endmodule

// File: tb/cbr_unit_test.sv
module cbr_unit_test;

    localparam int PW   = 10;
    localparam int MASK = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          phase_stb = 1'b0;
    logic [15:0]   instr = 16'h0000;
    logic          flag_zero = 1'b0;
    logic          flag_ovf = 1'b0;
    logic [PW-1:0] pc;
    logic          taken;
    logic          flush;

    int n_chk  = 0;
    int n_fail = 0;
    int m_pc   = 0;
    bit m_flush = 1'b0;

    always #2.5 clk = ~clk;

    cbr_unit #(.PC_W(PW)) uut (
        .clk       (clk),
        .rst       (rst),
        .phase_stb (phase_stb),
        .instr     (instr),
        .flag_zero (flag_zero),
        .flag_ovf  (flag_ovf),
        .pc        (pc),
        .taken     (taken),
        .flush     (flush)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_target(input int a, input logic [7:0] n);
        int d;
        d = int'($signed(n));
        return (a + 2 + 2 * d) & MASK;
    endfunction

    // One strobed clock, optionally preceded by idle clocks
    task automatic step_phase(input bit allow_gap);
        int gap;
        int pc0;
        gap = (allow_gap && ($urandom % 4 == 0)) ? 1 + int'($urandom % 2) : 0;
        pc0 = int'(pc);
        phase_stb = 1'b0;
        repeat (gap) @(negedge clk);
        if (gap > 0) chk(int'(pc) == pc0, "R9 idle hold pc", int'(pc), pc0);
        phase_stb = 1'b1;
        @(negedge clk);
        phase_stb = 1'b0;
    endtask

    task automatic do_cycle(input logic [15:0] w, input bit z, input bit v,
                            input bit flip, input bit gaps, input string tag);
        bit hit_nz, hit_nov, fl, take;
        int pc0;
        hit_nz  = (w[15:8] == 8'hE1);
        hit_nov = (w[15:8] == 8'hE5);
        fl      = hit_nz ? z : v;
        take    = !m_flush && (hit_nz || hit_nov) && !fl;
        pc0     = int'(pc);
        instr = w; flag_zero = z; flag_ovf = v;
        step_phase(gaps);
        if (flip) begin
            flag_zero = ~z;
            flag_ovf  = ~v;
        end
        step_phase(gaps);
        step_phase(gaps);
        chk(int'(pc) == pc0, {tag, " R11 pc held to phase 4"}, int'(pc), pc0);
        chk(taken == take, {tag, " R5 taken in phase 4"}, int'(taken), int'(take));
        step_phase(gaps);
        if (m_flush) begin
            m_flush = 1'b0;
        end else if (take) begin
            m_pc    = exp_target(m_pc, w[7:0]);
            m_flush = 1'b1;
        end else begin
            m_pc = (m_pc + 2) & MASK;
        end
        chk(int'(pc) == m_pc, {tag, " pc after phase 4"}, int'(pc), m_pc);
        chk(flush == m_flush, {tag, " flush after phase 4"}, int'(flush), int'(m_flush));
        chk(taken == 1'b0, {tag, " R5 taken drops"}, int'(taken), 0);
    endtask

    task automatic do_reset(input string tag);
        phase_stb = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pc = 0;
        m_flush = 1'b0;
        chk(pc == '0, {tag, " R10 pc"}, int'(pc), 0);
        chk(flush == 1'b0, {tag, " R10 flush"}, int'(flush), 0);
        chk(taken == 1'b0, {tag, " R10 taken"}, int'(taken), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        do_reset("reset");

        // R1: zero flag set -> not taken; clear -> taken
        do_cycle(16'hE105, 1'b1, 1'b0, 1'b0, 1'b0, "R1 bnz z=1");
        do_cycle(16'hE105, 1'b0, 1'b1, 1'b0, 1'b0, "R1 R3 bnz z=0 n=5");
        // R6: branch word in flush slot is discarded
        do_cycle(16'hE164, 1'b0, 1'b0, 1'b0, 1'b0, "R6 flush slot");
        // R2: overflow clear -> taken, n=-1 lands on own address
        do_cycle(16'hE5FF, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R3 bnov n=-1");
        do_cycle(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R6 flush nop");
        do_cycle(16'hE510, 1'b0, 1'b1, 1'b0, 1'b0, "R2 bnov v=1 z=0");
        do_cycle(16'hE110, 1'b1, 1'b0, 1'b0, 1'b0, "R1 bnz z=1 v=0");
        // R8: other upper bytes never branch
        do_cycle(16'hE210, 1'b0, 1'b0, 1'b0, 1'b0, "R8 opc E2");
        do_cycle(16'h00E1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 low byte E1");
        do_cycle(16'hE410, 1'b0, 1'b0, 1'b0, 1'b0, "R8 opc E4");
        // R7: flags change after phase 1
        do_cycle(16'hE120, 1'b1, 1'b1, 1'b1, 1'b0, "R7 late clear");
        do_cycle(16'hE520, 1'b0, 1'b0, 1'b1, 1'b0, "R7 late set");
        do_cycle(16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, "R6 nop after R7");
        // R3 extremes, wrap below zero and above the top
        do_reset("R10 before wrap");
        do_cycle(16'hE180, 1'b0, 1'b0, 1'b0, 1'b0, "R3 n=-128 wrap");
        do_cycle(16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, "R6 nop");
        do_cycle(16'hE57F, 1'b0, 1'b0, 1'b0, 1'b0, "R3 n=127 wrap");
        do_cycle(16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, "R6 nop");

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [15:0] w;
            int sel;
            sel = int'($urandom % 5);
            w[7:0] = 8'($urandom);
            case (sel)
                0, 1: w[15:8] = 8'hE1;
                2, 3: w[15:8] = 8'hE5;
                default: w[15:8] = 8'($urandom);
            endcase
            do_cycle(w, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, "R3 random");
        end

        // R10: reset in the middle of a taken branch
        instr = 16'hE140; flag_zero = 1'b0; flag_ovf = 1'b0;
        step_phase(1'b0);
        step_phase(1'b0);
        step_phase(1'b0);
        do_reset("R10 mid branch");
        do_cycle(16'hE140, 1'b1, 1'b0, 1'b0, 1'b0, "R10 phase 1 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule